// File: doc/BRIEF.md
# Stack Pointer Pair Interrupt Gate

This block holds the two stack pointers of a small processor core and decides whether interrupts may be taken at all. The wide pointer addresses stack entries of 16-bit data. The narrow pointer addresses stack entries of 4-bit data. Each pointer has its own write strobe and write data, and its own increment and decrement strobes for push and pop. Both pointers wrap around at the top and bottom of their ranges.

The interrupt gate stays closed after reset. It opens only once software has written both pointers as a pair. The gate applies to every request, the non-maskable one included. If software rewrites one pointer while the pair is complete, the gate closes again until the other pointer is also rewritten. A second output flags when the wide pointer has left the only region where 16-bit stack access is possible.

The interrupt controller takes the gate as a qualifier, and the core takes the two pointer values.

Top module: `sp_guard_unit`

## Requirements
- R1: While reset is asserted and after reset, both pointers read 0 and `irq_allow` is 0.
- R2: `irq_allow` becomes 1 only after both pointers have been written since reset, in either order. It changes in the cycle after the clock edge that takes the completing write.
- R3: While `irq_allow` is 1, a write to only one pointer drives `irq_allow` to 0 from the next cycle. It stays 0 until the other pointer is written. Writing the same pointer again does not reopen it.
- R4: Writing both pointers in the same cycle makes `irq_allow` 1 from the next cycle, whatever the previous state.
- R5: The wide pointer is 10 bits wide. A write loads `wide_wdata`. An increment adds 1 modulo 1024, so 0x3FF goes to 0x000. A decrement subtracts 1 modulo 1024, so 0x000 goes to 0x3FF.
- R6: The narrow pointer is 8 bits wide. A write loads `narrow_wdata`. Increment and decrement work modulo 256, so 0xFF goes to 0x00 and 0x00 goes to 0xFF.
- R7: For each pointer, a write in the same cycle as an increment or decrement takes priority. Increment and decrement together leave the pointer unchanged.
- R8: Increment and decrement strobes never change `irq_allow`.
- R9: `wide_outside` is 1 exactly when the wide pointer is below 0x100 or above 0x1FF. Both 0x100 and 0x1FF count as inside.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_wr | input | 1 | Write strobe for the wide pointer |
| wide_wdata | input | 10 | Write data for the wide pointer |
| wide_inc | input | 1 | Increment the wide pointer |
| wide_dec | input | 1 | Decrement the wide pointer |
| narrow_wr | input | 1 | Write strobe for the narrow pointer |
| narrow_wdata | input | 8 | Write data for the narrow pointer |
| narrow_inc | input | 1 | Increment the narrow pointer |
| narrow_dec | input | 1 | Decrement the narrow pointer |
| wide_ptr | output | 10 | Current wide pointer |
| narrow_ptr | output | 8 | Current narrow pointer |
| irq_allow | output | 1 | 1 when interrupts, the non-maskable one included, may be taken |
| wide_outside | output | 1 | 1 when the wide pointer is outside the 16-bit access window |

## Verification
The bench builds the block with its default parameters: a 10-bit wide pointer, an 8-bit narrow pointer and a window from 0x100 to 0x1FF. With these widths, a single decrement from reset reaches the lower wrap, and a single write followed by one increment reaches the upper wrap. Both window edges and their outer neighbours can be reached with direct writes. A reference model that tracks the pairing flags as plain booleans is stepped alongside the design through directed sequences, a mid-run reset and a random stretch. The random stretch mixes writes, collisions and simultaneous strobes.

// File: rtl/sp_pkg.sv
package sp_pkg;
    // Pairing state: one "written since the pair was last broken" bit per pointer
    typedef struct packed {
        logic wide_done;
        logic narrow_done;
    } pair_flags_t;

    // Action selected for a pointer in one cycle
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_LOAD = 2'd3
    } step_e;

    function automatic step_e pick_step(input logic load, input logic inc, input logic dec);
        if (load)            return STEP_LOAD;
        else if (inc && !dec) return STEP_UP;
        else if (dec && !inc) return STEP_DOWN;
        else                  return STEP_HOLD;
    endfunction
endpackage

// File: rtl/sp_pointer.sv
module sp_pointer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] ptr
);
    import sp_pkg::*;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t state_d, state_q;
    step_e      step;

    always_comb begin
        state_d = state_q;
        step    = pick_step(load, inc, dec);
        case (step)
            STEP_LOAD: state_d.ptr = load_val;
            STEP_UP:   state_d.ptr = state_q.ptr + ONE;
            STEP_DOWN: state_d.ptr = state_q.ptr - ONE;
            default:   state_d.ptr = state_q.ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ptr = state_q.ptr;

    // A write lands on the next cycle (R5, R6, R7)
    assert_load_value_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ptr == $past(load_val));

    // Increment wraps modulo 2**W (R5, R6)
    assert_inc_wrap_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && inc && !dec) |=> ptr == W'($past(ptr) + ONE));

    // Decrement wraps modulo 2**W (R5, R6)
    assert_dec_wrap_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && !inc) |=> ptr == W'($past(ptr) - ONE));

    // Opposing strobes cancel (R7)
    assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && inc && dec) |=> $stable(ptr));
endmodule

// File: rtl/sp_pair_tracker.sv
module sp_pair_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_wide,
    input  logic wr_narrow,
    output logic allow
);
    import sp_pkg::*;

    pair_flags_t flags_d, flags_q;
    logic        pair_complete;

    assign pair_complete = flags_q.wide_done && flags_q.narrow_done;

    always_comb begin
        flags_d = flags_q;
        if (wr_wide && wr_narrow) begin
            flags_d.wide_done   = 1'b1;
            flags_d.narrow_done = 1'b1;
        end else if (wr_wide) begin
            flags_d.wide_done = 1'b1;
            if (pair_complete) flags_d.narrow_done = 1'b0;
        end else if (wr_narrow) begin
            flags_d.narrow_done = 1'b1;
            if (pair_complete) flags_d.wide_done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // Gate is combinational from the registered flags
    assign allow = pair_complete;

    // Opening needs a write on the edge before (R2)
    assert_open_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(allow) |-> $past(wr_wide || wr_narrow));

    // Breaking the pair closes the gate (R3)
    assert_rewrite_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (allow && (wr_wide != wr_narrow)) |=> !allow);

    // Joint write completes the pair at once (R4)
    assert_joint_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_wide && wr_narrow) |=> allow);

    // Without writes the pairing state never moves (R8)
    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_wide && !wr_narrow) |=> $stable(flags_q));
endmodule

// File: rtl/sp_window.sv
module sp_window #(
    parameter int           W  = 10,
    parameter logic [W-1:0] LO = '0,
    parameter logic [W-1:0] HI = '1
) (
    input  logic [W-1:0] ptr,
    output logic         outside
);
    always_comb begin
        outside = (ptr < LO) || (ptr > HI);
    end
endmodule

// File: rtl/sp_guard_unit.sv
module sp_guard_unit #(
    parameter int                 WIDE_W   = 10,
    parameter int                 NARROW_W = 8,
    parameter logic [WIDE_W-1:0]  WIN_LO   = 10'h100,
    parameter logic [WIDE_W-1:0]  WIN_HI   = 10'h1FF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wide_wr,
    input  logic [WIDE_W-1:0]   wide_wdata,
    input  logic                wide_inc,
    input  logic                wide_dec,
    input  logic                narrow_wr,
    input  logic [NARROW_W-1:0] narrow_wdata,
    input  logic                narrow_inc,
    input  logic                narrow_dec,
    output logic [WIDE_W-1:0]   wide_ptr,
    output logic [NARROW_W-1:0] narrow_ptr,
    output logic                irq_allow,
    output logic                wide_outside
);
    sp_pointer #(.W(WIDE_W)) u_wide (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wide_wr),
        .load_val (wide_wdata),
        .inc      (wide_inc),
        .dec      (wide_dec),
        .ptr      (wide_ptr)
    );

    sp_pointer #(.W(NARROW_W)) u_narrow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (narrow_wr),
        .load_val (narrow_wdata),
        .inc      (narrow_inc),
        .dec      (narrow_dec),
        .ptr      (narrow_ptr)
    );

    sp_pair_tracker u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_wide   (wide_wr),
        .wr_narrow (narrow_wr),
        .allow     (irq_allow)
    );

    sp_window #(.W(WIDE_W), .LO(WIN_LO), .HI(WIN_HI)) u_win (
        .ptr     (wide_ptr),
        .outside (wide_outside)
    );

    // Pointer updates alone never move the gate (R8)
    assert_strobes_no_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_wr && !narrow_wr) |=> $stable(irq_allow));

    // Gate closed in the first cycle out of reset (R1)
    assert_reset_closed_R1: assert property (@(posedge clk)
        !rst_n |=> !irq_allow || $past(wide_wr && narrow_wr));
endmodule

// File: tb/test_sp_guard_unit.sv
module test_sp_guard_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wide_wr = 0, wide_inc = 0, wide_dec = 0;
    logic [9:0] wide_wdata = '0;
    logic       narrow_wr = 0, narrow_inc = 0, narrow_dec = 0;
    logic [7:0] narrow_wdata = '0;
    logic [9:0] wide_ptr;
    logic [7:0] narrow_ptr;
    logic       irq_allow, wide_outside;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_wide = 0, m_narrow = 0;
    bit m_wset = 0, m_nset = 0;

    always #5 clk = ~clk;

    sp_guard_unit i_sp_guard_unit (
        .clk(clk), .rst_n(rst_n),
        .wide_wr(wide_wr), .wide_wdata(wide_wdata), .wide_inc(wide_inc), .wide_dec(wide_dec),
        .narrow_wr(narrow_wr), .narrow_wdata(narrow_wdata), .narrow_inc(narrow_inc), .narrow_dec(narrow_dec),
        .wide_ptr(wide_ptr), .narrow_ptr(narrow_ptr), .irq_allow(irq_allow), .wide_outside(wide_outside)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        bit exp_out;
        exp_out = (m_wide < 'h100) || (m_wide > 'h1FF);
        check(tag, "wide_ptr", int'(wide_ptr), m_wide);
        check(tag, "narrow_ptr", int'(narrow_ptr), m_narrow);
        check(tag, "irq_allow", int'(irq_allow), int'(m_wset && m_nset));
        check("R9", "wide_outside", int'(wide_outside), int'(exp_out));
    endtask

    // One cycle: inputs applied at negedge, model advanced, outputs compared at next negedge
    task automatic cyc(input bit ww, input int wd, input bit wi, input bit wdn,
                       input bit nw, input int nd, input bit ni, input bit ndn,
                       input string tag);
        wide_wr = ww; wide_wdata = 10'(wd); wide_inc = wi; wide_dec = wdn;
        narrow_wr = nw; narrow_wdata = 8'(nd); narrow_inc = ni; narrow_dec = ndn;
        // pointer model
        if (ww) m_wide = wd % 1024;
        else if (wi && !wdn) m_wide = (m_wide + 1) % 1024;
        else if (wdn && !wi) m_wide = (m_wide + 1023) % 1024;
        if (nw) m_narrow = nd % 256;
        else if (ni && !ndn) m_narrow = (m_narrow + 1) % 256;
        else if (ndn && !ni) m_narrow = (m_narrow + 255) % 256;
        // pairing model: a lone write while paired forgets the partner
        if (ww && nw) begin
            m_wset = 1; m_nset = 1;
        end else if (ww) begin
            if (m_wset && m_nset) m_nset = 0;
            m_wset = 1;
        end else if (nw) begin
            if (m_wset && m_nset) m_wset = 0;
            m_nset = 1;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wide_wr = 0; wide_inc = 0; wide_dec = 0;
        narrow_wr = 0; narrow_inc = 0; narrow_dec = 0;
        m_wide = 0; m_narrow = 0; m_wset = 0; m_nset = 0;
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R5 lower wrap, R6 increments, R8 strobes leave the gate shut
        cyc(0, 0, 0, 1, 0, 0, 1, 0, "R5");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R8");
        // R2 first pointer alone keeps the gate closed; window lower edge (R9)
        cyc(1, 'h100, 0, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, "R9"); // 0x0FF outside
        cyc(1, 'h100, 0, 0, 0, 0, 0, 0, "R2"); // rewriting same pointer, still closed
        cyc(0, 0, 0, 0, 1, 'h80, 0, 0, "R2"); // pair complete -> open
        // R9 upper edge
        cyc(1, 'h1FF, 0, 0, 0, 0, 0, 0, "R3"); // lone write while open closes
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R9"); // 0x200 outside
        cyc(1, 'h1FF, 0, 0, 0, 0, 0, 0, "R3"); // same pointer again, stays closed
        cyc(0, 0, 0, 0, 1, 'h10, 0, 0, "R3"); // partner written -> open
        // R8 strobes while open
        cyc(0, 0, 1, 0, 0, 0, 0, 1, "R8");
        cyc(0, 0, 0, 1, 0, 0, 1, 0, "R8");
        // R7 cancel and write priority
        cyc(0, 0, 1, 1, 0, 0, 1, 1, "R7");
        cyc(1, 'h155, 1, 0, 0, 0, 0, 0, "R7"); // closes too (R3)
        cyc(0, 0, 0, 0, 1, 'h33, 0, 1, "R7"); // reopens
        // R4 joint write while open
        cyc(1, 'h120, 0, 0, 1, 'hFF, 0, 0, "R4");
        // R6 upper and lower narrow wraps
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, "R6");
        // R5 upper wide wrap
        cyc(1, 'h3FF, 0, 0, 1, 0, 0, 0, "R5");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R5");

        // R1 mid-run reset, then R4 joint write from cleared state
        do_reset();
        cyc(1, 'h1A0, 0, 0, 1, 'h40, 0, 0, "R4");
        // R3 narrow rewrite closes
        cyc(0, 0, 0, 0, 1, 'h41, 0, 0, "R3");
        idle("R3");

        // random mix compared every cycle against the model
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            cyc((r[3:0] == 0), r[13:4] % 1024, r[14], r[15],
                (r[19:16] == 0), r[27:20], r[28], r[29], "R2");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule